// File: doc/BRIEF.md
# Low-Power State Controller

This block sequences a processor core between full operation and three static low-power states of increasing depth: light (doze), deeper (nap) and deepest (sleep). Software sets a master enable, picks a state with three request bits and then issues a one-cycle entry strobe. In each state the block drives a set of clock enables: one per execution unit, one for the bus snoop logic and one for the timer (time base and decrementer). It also drives a hint that tells the clock generator to keep its PLL running. In full operation an optional dynamic mode turns off the clock of each execution unit that reports itself idle, without delaying any unit that is busy.

A low-power state ends on a wake event that the current state accepts. Leaving doze or nap passes through a short resume stage and then returns to full operation. Leaving sleep first waits for the clock-valid input to rise. A programmable relock count then has to run out before the core resumes. Wake events that arrive during this wait are held until the count ends.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset the state is full (code 0), every unit enable, the snoop enable, the timer enable and the PLL hint are high when dynamic gating is off, and no wake is pending.
- R2: In full state with `dyn_en_i` high, each unit enable follows that unit's busy bit in the same cycle. With `dyn_en_i` low, all unit enables are high. A busy unit is never gated in full state.
- R3: A high `lp_go_i` in full state, with `pm_en_i` high and at least one request bit set, moves the state at the next edge. State codes: 0 full, 1 doze, 2 nap, 3 sleep, 4 relock, 5 resume. The strobe has no effect when `pm_en_i` is low or when no request bit is set.
- R4: When several request bits are set, sleep wins over nap and nap wins over doze.
- R5: In doze, unit enables are low, while the snoop enable, the timer enable and the PLL hint are high.
- R6: In nap, unit and snoop enables are low, while the timer enable and the PLL hint are high.
- R7: In sleep and relock, every enable and the PLL hint are low.
- R8: Wake bits are `wake_i[0]` external interrupt, `[1]` system management interrupt, `[2]` decrementer, `[3]` machine check, `[4]` soft reset. In doze or nap, any of the five bits moves the state to resume at the next edge.
- R9: In sleep the decrementer bit has no effect, and the other four bits are held pending. A rise of `clk_valid_i` moves sleep to relock, where the count loads `relock_len_i`. Relock lasts at least `relock_len_i`+1 cycles and goes to resume on the first edge where the count is spent and a wake is pending or present. If `clk_valid_i` drops during relock, the state returns to sleep.
- R10: Resume lasts `WAKE_LAT` cycles, with unit enables low and the snoop enable, timer enable and PLL hint high. The state then returns to full.
- R11: An entry strobe that arrives in the same cycle as a wake bit the target state accepts leaves the state in full. A wake bit the target does not accept (the decrementer when the target is sleep) does not cancel the entry.
- R12: Reset clears a pending sleep wake. After a reset, a new sleep stays in relock until a fresh wake arrives.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low reset |
| pm_en_i | input | 1 | Master power-management enable |
| req_doze_i | input | 1 | Request bit for doze |
| req_nap_i | input | 1 | Request bit for nap |
| req_sleep_i | input | 1 | Request bit for sleep |
| dyn_en_i | input | 1 | Dynamic idle gating enable |
| lp_go_i | input | 1 | Entry strobe |
| wake_i | input | 5 | Wake events, bit order as in R8 |
| clk_valid_i | input | 1 | System clock/PLL valid |
| relock_len_i | input | CNT_W | Relock wait in cycles |
| unit_busy_i | input | N_UNITS | Per-unit busy flags |
| unit_clk_en_o | output | N_UNITS | Per-unit clock enables |
| snoop_clk_en_o | output | 1 | Snoop logic clock enable |
| tb_clk_en_o | output | 1 | Timer clock enable |
| pll_keep_o | output | 1 | Keep-PLL-running hint |
| pwr_state_o | output | 3 | Current state code (R3) |

## Verification
Two events can land on the same edge: an entry strobe and a wake event. The second such pair is the end of the relock count and a wake. The bench drives the strobe and a wake bit at the same falling edge. It expects the state to stay full when the target accepts that wake bit. It expects the entry to go ahead when the only wake bit is the decrementer and the target is sleep. For the relock pair, a system management interrupt is applied in the cycle after the count has run out, and the state must reach resume on exactly that edge. A decrementer pulse in the same window must leave the state in relock.

// File: rtl/pwr_mode_pkg.sv
package pwr_mode_pkg;

  localparam int NUM_WAKE = 5;
  localparam int WK_EXT   = 0;
  localparam int WK_SMI   = 1;
  localparam int WK_DEC   = 2;
  localparam int WK_MCHK  = 3;
  localparam int WK_SRST  = 4;

  typedef enum logic [2:0] {
    PS_FULL   = 3'd0,
    PS_DOZE   = 3'd1,
    PS_NAP    = 3'd2,
    PS_SLEEP  = 3'd3,
    PS_RELOCK = 3'd4,
    PS_RESUME = 3'd5
  } pstate_e;

  // Deepest requested state wins.
  function automatic pstate_e pick_mode(input logic d, input logic n, input logic s);
    pstate_e r;
    r = PS_DOZE;
    if (n) r = PS_NAP;
    if (s) r = PS_SLEEP;
    if (!(d || n || s)) r = PS_FULL;
    return r;
  endfunction

  // Wake sources accepted while resting in (or targeting) a state.
  function automatic logic [NUM_WAKE-1:0] wake_mask(input pstate_e st);
    logic [NUM_WAKE-1:0] m;
    case (st)
      PS_DOZE, PS_NAP:     m = '1;
      PS_SLEEP, PS_RELOCK: begin
        m = '1;
        m[WK_DEC] = 1'b0;
      end
      default:             m = '0;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/pm_cycle_timer.sv
module pm_cycle_timer #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] len,
  input  logic         run,
  output logic         done
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                       cnt_q <= '0;
    else if (load)                    cnt_q <= len;
    else if (run && (cnt_q != '0))    cnt_q <= cnt_q - 1'b1;
  end

  assign done = (cnt_q == '0);

  // R9: a running count steps down by exactly one per cycle
  a_r9_count_steps_by_one: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !load && (cnt_q != '0)) |=> (cnt_q == W'($past(cnt_q) - 1'b1)));

endmodule

// File: rtl/pm_mode_select.sv
module pm_mode_select
  import pwr_mode_pkg::*;
(
  input  pstate_e              st,
  input  logic                 pm_en,
  input  logic                 req_doze,
  input  logic                 req_nap,
  input  logic                 req_sleep,
  input  logic                 lp_go,
  input  logic [NUM_WAKE-1:0]  wake,
  output pstate_e              tgt,
  output logic                 collide,
  output logic                 enter_ok
);
  logic any_req;

  assign any_req  = req_doze | req_nap | req_sleep;
  assign tgt      = pick_mode(req_doze, req_nap, req_sleep);
  assign collide  = |(wake & wake_mask(tgt));
  assign enter_ok = (st == PS_FULL) && lp_go && pm_en && any_req && !collide;

  // R4: a granted entry never selects a shallower state than requested
  always_comb begin
    if (enter_ok && req_sleep) a_r4_sleep_first: assert (tgt == PS_SLEEP);
  end
endmodule

// File: rtl/pm_wake_qual.sv
module pm_wake_qual
  import pwr_mode_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  pstate_e             st,
  input  logic [NUM_WAKE-1:0] wake,
  output logic                wake_hit,
  output logic                pend
);
  logic in_sl;

  assign in_sl    = (st == PS_SLEEP) || (st == PS_RELOCK);
  assign wake_hit = |(wake & wake_mask(st));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     pend <= 1'b0;
    else if (in_sl) pend <= pend | wake_hit;
    else            pend <= 1'b0;
  end

  // R12: nothing stays pending once the sleep path is left
  a_r12_pend_dropped_outside_sleep: assert property (@(posedge clk) disable iff (!rst_n)
    !in_sl |=> !pend);

  // R9: a lone decrementer event is never latched in sleep
  a_r9_dec_not_latched: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sl && !pend && (wake == (NUM_WAKE'(1) << WK_DEC))) |=> !pend);
endmodule

// File: rtl/pm_domain_gate.sv
module pm_domain_gate
  import pwr_mode_pkg::*;
#(
  parameter int N_UNITS = 4
) (
  input  logic               clk,
  input  logic               rst_n,
  input  pstate_e            st,
  input  logic               dyn_en,
  input  logic [N_UNITS-1:0] busy,
  output logic [N_UNITS-1:0] unit_en,
  output logic               snoop_en,
  output logic               tb_en,
  output logic               pll_keep
);
  logic full_q;
  assign full_q = (st == PS_FULL);

  for (genvar i = 0; i < N_UNITS; i++) begin : g_unit
    assign unit_en[i] = full_q & (~dyn_en | busy[i]);
  end

  assign snoop_en = (st == PS_FULL) || (st == PS_DOZE) || (st == PS_RESUME);
  assign tb_en    = snoop_en || (st == PS_NAP);
  assign pll_keep = (st != PS_SLEEP) && (st != PS_RELOCK);

  // R2: a busy unit keeps its clock in full state
  a_r2_busy_never_gated: assert property (@(posedge clk) disable iff (!rst_n)
    full_q |-> ((busy & ~unit_en) == '0));
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pwr_mode_pkg::*;
#(
  parameter int N_UNITS  = 4,
  parameter int CNT_W    = 16,
  parameter int WAKE_LAT = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pm_en_i,
  input  logic                 req_doze_i,
  input  logic                 req_nap_i,
  input  logic                 req_sleep_i,
  input  logic                 dyn_en_i,
  input  logic                 lp_go_i,
  input  logic [4:0]           wake_i,
  input  logic                 clk_valid_i,
  input  logic [CNT_W-1:0]     relock_len_i,
  input  logic [N_UNITS-1:0]   unit_busy_i,
  output logic [N_UNITS-1:0]   unit_clk_en_o,
  output logic                 snoop_clk_en_o,
  output logic                 tb_clk_en_o,
  output logic                 pll_keep_o,
  output logic [2:0]           pwr_state_o
);
  localparam int RES_W = (WAKE_LAT < 2) ? 1 : $clog2(WAKE_LAT + 1);

  pstate_e st_q, st_d, tgt;
  logic    enter_ok, collide, wake_hit, wake_pend;
  logic    cv_q, cv_rise;
  logic    relock_load, relock_done, res_load, res_done;

  pm_mode_select u_sel (
    .st(st_q), .pm_en(pm_en_i), .req_doze(req_doze_i), .req_nap(req_nap_i),
    .req_sleep(req_sleep_i), .lp_go(lp_go_i), .wake(wake_i),
    .tgt(tgt), .collide(collide), .enter_ok(enter_ok)
  );

  pm_wake_qual u_wq (
    .clk(clk), .rst_n(rst_n), .st(st_q), .wake(wake_i),
    .wake_hit(wake_hit), .pend(wake_pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cv_q <= 1'b0;
    else        cv_q <= clk_valid_i;
  end
  assign cv_rise = clk_valid_i & ~cv_q;

  always_comb begin
    st_d = st_q;
    case (st_q)
      PS_FULL:          if (enter_ok) st_d = tgt;
      PS_DOZE, PS_NAP:  if (wake_hit) st_d = PS_RESUME;
      PS_SLEEP:         if (cv_rise)  st_d = PS_RELOCK;
      PS_RELOCK: begin
        if (!clk_valid_i)                          st_d = PS_SLEEP;
        else if (relock_done && (wake_pend || wake_hit)) st_d = PS_RESUME;
      end
      PS_RESUME:        if (res_done) st_d = PS_FULL;
      default:          st_d = PS_FULL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= PS_FULL;
    else        st_q <= st_d;
  end

  assign relock_load = (st_d == PS_RELOCK) && (st_q != PS_RELOCK);
  assign res_load    = (st_d == PS_RESUME) && (st_q != PS_RESUME);

  pm_cycle_timer #(.W(CNT_W)) u_relock (
    .clk(clk), .rst_n(rst_n), .load(relock_load), .len(relock_len_i),
    .run(st_q == PS_RELOCK), .done(relock_done)
  );

  pm_cycle_timer #(.W(RES_W)) u_resume (
    .clk(clk), .rst_n(rst_n), .load(res_load), .len(RES_W'(WAKE_LAT - 1)),
    .run(st_q == PS_RESUME), .done(res_done)
  );

  pm_domain_gate #(.N_UNITS(N_UNITS)) u_gate (
    .clk(clk), .rst_n(rst_n), .st(st_q), .dyn_en(dyn_en_i), .busy(unit_busy_i),
    .unit_en(unit_clk_en_o), .snoop_en(snoop_clk_en_o), .tb_en(tb_clk_en_o),
    .pll_keep(pll_keep_o)
  );

  assign pwr_state_o = st_q;

  // R8: doze and nap leave only through resume
  a_r8_light_exit_via_resume: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == PS_DOZE) || (st_q == PS_NAP)) |=> ((st_q == $past(st_q)) || (st_q == PS_RESUME)));

  // R9: sleep moves only to relock
  a_r9_sleep_to_relock_only: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_SLEEP) |=> ((st_q == PS_SLEEP) || (st_q == PS_RELOCK)));

  // R9: no resume before the relock count is spent
  a_r9_no_early_resume: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == PS_RELOCK) && !relock_done) |=> (st_q != PS_RESUME));

  // R7: the PLL hint is low throughout sleep
  a_r7_sleep_pll_off: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_SLEEP) |-> !pll_keep_o);

  // R10: resume ends in full once its count is spent
  a_r10_resume_to_full: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == PS_RESUME) && res_done) |=> (st_q == PS_FULL));

  // R11: an entry colliding with an accepted wake stays in full
  a_r11_collision_blocks_entry: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q == PS_FULL) && lp_go_i && collide) |=> (st_q == PS_FULL));

  // R12: full state never carries a pending sleep wake
  a_r12_no_pend_in_full: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == PS_FULL) |-> !wake_pend);
endmodule

// File: tb/pwr_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module pwr_mode_ctrl_tb_top;
  localparam int NU = 4;
  localparam int CW = 16;
  localparam int WL = 3;
  localparam int RL = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pm_en = 1'b1, rq_d = 1'b0, rq_n = 1'b0, rq_s = 1'b0, dyn = 1'b0, go = 1'b0;
  logic [4:0] wake = '0;
  logic cval = 1'b1;
  logic [CW-1:0] rlen = CW'(RL);
  logic [NU-1:0] busy = '0;
  logic [NU-1:0] u_en;
  logic sn_en, tb_en, pll;
  logic [2:0] st;

  int n_cmp = 0;
  int n_bad = 0;

  always #2.5 clk = ~clk;

  pwr_mode_ctrl #(.N_UNITS(NU), .CNT_W(CW), .WAKE_LAT(WL)) dut_i (
    .clk(clk), .rst_n(rst_n), .pm_en_i(pm_en), .req_doze_i(rq_d), .req_nap_i(rq_n),
    .req_sleep_i(rq_s), .dyn_en_i(dyn), .lp_go_i(go), .wake_i(wake),
    .clk_valid_i(cval), .relock_len_i(rlen), .unit_busy_i(busy),
    .unit_clk_en_o(u_en), .snoop_clk_en_o(sn_en), .tb_clk_en_o(tb_en),
    .pll_keep_o(pll), .pwr_state_o(st)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  // Expected enables restated from the per-state rules (R2, R5-R7, R10)
  task automatic chk_all(input string tag, input int s);
    logic [NU-1:0] eu;
    logic es, et, ep;
    eu = (s == 0) ? (dyn ? busy : '1) : '0;
    es = (s == 0) || (s == 1) || (s == 5);
    et = (s == 0) || (s == 1) || (s == 2) || (s == 5);
    ep = !((s == 3) || (s == 4));
    #1;
    chk({tag, " state"}, 32'(st), 32'(s));
    chk({tag, " units"}, 32'(u_en), 32'(eu));
    chk({tag, " snoop"}, 32'(sn_en), 32'(es));
    chk({tag, " timer"}, 32'(tb_en), 32'(et));
    chk({tag, " pll"}, 32'(pll), 32'(ep));
  endtask

  task automatic lp_enter(input logic d, input logic n, input logic s);
    rq_d = d; rq_n = n; rq_s = s; go = 1'b1;
    step(1);
    go = 1'b0;
  endtask

  task automatic pulse_wake(input logic [4:0] v);
    wake = v;
    step(1);
    wake = '0;
  endtask

  // From sleep with a wake already pending: clock returns, relock, resume, full
  task automatic leave_sleep();
    cval = 1'b0; step(1);
    cval = 1'b1; step(RL + 2 + WL);
  endtask

  task automatic t_reset();
    chk_all("R1 reset", 0);
  endtask

  task automatic t_dyn();
    dyn = 1'b1; busy = 4'b0101;
    chk_all("R2 dyn pattern a", 0);
    busy = 4'b1110;
    chk_all("R2 dyn pattern b", 0);
    dyn = 1'b0;
    chk_all("R2 dyn off", 0);
    busy = '0;
  endtask

  task automatic t_ignore();
    pm_en = 1'b0; lp_enter(1'b1, 1'b0, 1'b0);
    chk("R3 master off", 32'(st), 32'd0);
    pm_en = 1'b1; lp_enter(1'b0, 1'b0, 1'b0);
    chk("R3 no request bit", 32'(st), 32'd0);
  endtask

  task automatic t_doze();
    for (int b = 0; b < 5; b++) begin
      lp_enter(1'b1, 1'b0, 1'b0);
      chk_all("R5 doze", 1);
      pulse_wake(5'(1 << b));
      chk_all("R8 doze wake", 5);
      step(WL - 1);
      chk("R10 still resume", 32'(st), 32'd5);
      step(1);
      chk_all("R10 back to full", 0);
    end
  endtask

  task automatic t_nap();
    lp_enter(1'b0, 1'b1, 1'b0);
    chk_all("R6 nap", 2);
    step(3);
    chk("R6 nap holds", 32'(st), 32'd2);
    pulse_wake(5'b00100);
    chk_all("R8 nap dec wake", 5);
    step(WL);
    chk("R10 nap resume done", 32'(st), 32'd0);
  endtask

  task automatic t_prio();
    lp_enter(1'b1, 1'b1, 1'b1);
    chk("R4 sleep wins", 32'(st), 32'd3);
    pulse_wake(5'b00001);
    leave_sleep();
    chk("R4 sleep left", 32'(st), 32'd0);
    lp_enter(1'b1, 1'b1, 1'b0);
    chk("R4 nap over doze", 32'(st), 32'd2);
    pulse_wake(5'b00001);
    step(WL);
    chk("R4 nap left", 32'(st), 32'd0);
  endtask

  task automatic t_sleep();
    lp_enter(1'b0, 1'b0, 1'b1);
    chk_all("R7 sleep", 3);
    pulse_wake(5'b00100);
    chk("R9 dec ignored in sleep", 32'(st), 32'd3);
    cval = 1'b0; step(2);
    pulse_wake(5'b00001);
    chk("R9 wake held before clock", 32'(st), 32'd3);
    cval = 1'b1; step(1);
    chk_all("R7 relock", 4);
    step(RL);
    chk("R9 relock full length", 32'(st), 32'd4);
    step(1);
    chk_all("R10 resume after relock", 5);
    step(WL);
    chk_all("R10 sleep back to full", 0);
  endtask

  task automatic t_sleep_late();
    lp_enter(1'b0, 1'b0, 1'b1);
    cval = 1'b0; step(1);
    cval = 1'b1; step(1);
    chk("R9 relock entered", 32'(st), 32'd4);
    step(RL + 3);
    chk("R9 expired, no wake", 32'(st), 32'd4);
    pulse_wake(5'b00100);
    chk("R9 dec ignored in relock", 32'(st), 32'd4);
    cval = 1'b0; step(1);
    chk("R9 clock drop back to sleep", 32'(st), 32'd3);
    cval = 1'b1; step(1);
    step(RL + 1);
    chk("R9 relock spent", 32'(st), 32'd4);
    pulse_wake(5'b00010);
    chk("R9 live wake after count", 32'(st), 32'd5);
    step(WL);
    chk("R10 full again", 32'(st), 32'd0);
  endtask

  task automatic t_collide();
    rq_d = 1'b0; rq_n = 1'b1; rq_s = 1'b0; go = 1'b1; wake = 5'b00001;
    step(1);
    go = 1'b0; wake = '0;
    chk("R11 accepted wake cancels entry", 32'(st), 32'd0);
    rq_n = 1'b0; rq_s = 1'b1; go = 1'b1; wake = 5'b00100;
    step(1);
    go = 1'b0; wake = '0;
    chk("R11 dec does not cancel sleep", 32'(st), 32'd3);
    pulse_wake(5'b01000);
    leave_sleep();
    chk("R11 sleep left", 32'(st), 32'd0);
  endtask

  task automatic t_reset_pend();
    lp_enter(1'b0, 1'b0, 1'b1);
    pulse_wake(5'b10000);
    rst_n = 1'b0; step(2);
    chk_all("R12 reset in sleep", 0);
    rst_n = 1'b1; step(1);
    lp_enter(1'b0, 1'b0, 1'b1);
    cval = 1'b0; step(1);
    cval = 1'b1; step(RL + 4);
    chk("R12 pending cleared by reset", 32'(st), 32'd4);
    pulse_wake(5'b00001);
    step(WL);
    chk("R12 fresh wake exits", 32'(st), 32'd0);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset();
    t_dyn();
    t_ignore();
    t_doze();
    t_nap();
    t_prio();
    t_sleep();
    t_sleep_late();
    t_collide();
    t_reset_pend();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule